// File: doc/BRIEF.md
# Display Panel Command Interpreter

This block decodes the byte stream that a small LCD panel controller receives over its serial link. Every accepted byte is either a new command or a parameter of the command in progress. The block keeps the panel's mode flags (sleep, booster, tearing-effect, partial / normal / scroll mode, inversion, display on, gamma and a self-diagnostic byte) and updates them as commands complete.

Each transfer also returns one byte to the host. That byte comes from a small response buffer. Read commands fill the buffer with identification or packed status bytes, so their data appears on the transfers that follow the read command. Bytes that name no decoded command raise a one-cycle error pulse and change nothing else.

Top module: `lcdc_cmd_interp`

## Requirements
- R1: After reset, and after command 0x01, the flags are as follows: sleep 1, booster 0, tearing-effect 0, partial 0, normal 1, scroll 0, invert 0, display-on 1, gamma 0. The self-diagnostic byte is 0xB0. After reset the response buffer is empty and `tx_byte` is 0x00.
- R2: While `rx_valid` is high, `tx_byte` shows the queued response byte for that transfer, and the queue then advances by one entry. Once every loaded entry has been returned, transfers return 0x00. A read command empties the queue and refills it. The read command's own transfer still returns the byte that was queued before it.
- R3: Command 0x04 queues the panel ID 0x838F03 as three bytes, 0x83 then 0x8F then 0x03. Commands 0xDA, 0xDB and 0xDC each queue one of these bytes, in that order, on its own.
- R4: Command 0x09 queues four status bytes:
  - 0: booster<<7
  - 1: 0x50 | partial<<2 | sleep<<1 | normal
  - 2: scroll<<7 | invert<<5 | display-on<<2 | te<<1 | gamma bit 2
  - 3: gamma bits 1:0 shifted left by 6
- R5: Single-byte reads:
  - 0x0A: booster<<7 | sleep<<6 | partial<<5 | sleep<<4 | normal<<3 | display-on<<2
  - 0x0B: 0x00
  - 0x0C: 0x05
  - 0x0D: scroll<<7 | invert<<5 | gamma
  - 0x0E: te<<7
  - 0x0F: the self-diagnostic byte
  - 0x06, 0x07, 0x08: 0x01
- R6: Command 0x10 sets sleep. Command 0x11 clears sleep and inverts bit 6 of the self-diagnostic byte.
- R7: Command 0x12 selects partial mode, 0x13 selects normal mode and 0x37 selects scroll mode. Exactly one of the three mode flags is set at any time.
- R8: Command 0x26 takes one parameter byte, and so does 0x35. Commands 0xB0, 0xB1 and 0xC2 take two parameter bytes, which are discarded. A parameter byte is never decoded as a command, and it raises no error.
- R9: When the 0x26 parameter arrives and its low nibble is non-zero, gamma becomes the index of the lowest set bit of that nibble. A zero nibble leaves gamma unchanged.
- R10: Commands 0x02 and 0x03 clear and set booster. Commands 0x20 and 0x21 clear and set invert. Commands 0x28 and 0x29 clear and set display-on. Command 0x34 clears tearing-effect, and the parameter byte of 0x35 sets it.
- R11: Command 0x01 restores every flag and the self-diagnostic byte to the R1 values. It does not alter the response queue.
- R12: A command byte outside the decoded set (for example 0x05, 0x2C or 0xFF) drives `cmd_error` high for exactly the cycle after its transfer and leaves the flags unchanged. The decoded set is every code named in R1 to R11, plus 0x00 and 0xB4, which are accepted as no-ops. Decoded commands and parameter bytes leave `cmd_error` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received command or parameter byte |
| tx_byte | output | 8 | Response byte returned for the current transfer |
| cmd_error | output | 1 | One-cycle pulse after an undecoded command byte |

## Verification
The bench builds the block with its default parameters: a four-entry response queue, a two-bit parameter counter and the panel ID 0x838F03. A four-deep queue lets a single status read drain the queue completely, so the fall-back to 0x00 is reached within a few transfers. The two-bit counter covers the longest parameter run of two bytes. The bench sends bytes back to back, which covers a parameter byte that carries a command code, a read issued while an older read is only half drained, and a software reset while a readback is queued.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

  typedef struct packed {
    logic       sleep;
    logic       booster;
    logic       te;
    logic       partial;
    logic       normal;
    logic       scroll;
    logic       invert;
    logic       disp_on;
    logic [2:0] gamma;
    logic [7:0] diag;
  } lcdc_flags_t;

  localparam logic [7:0] DIAG_INIT = 8'hB0;

  function automatic lcdc_flags_t flags_init();
    lcdc_flags_t f;
    f = '0;
    f.sleep   = 1'b1;
    f.normal  = 1'b1;
    f.disp_on = 1'b1;
    f.diag    = DIAG_INIT;
    return f;
  endfunction

  // number of parameter bytes that follow a command code
  function automatic logic [1:0] param_need(input logic [7:0] code);
    case (code)
      8'h26, 8'h35:        return 2'd1;
      8'hB0, 8'hB1, 8'hC2: return 2'd2;
      default:             return 2'd0;
    endcase
  endfunction

  function automatic logic is_read(input logic [7:0] code);
    case (code)
      8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D,
      8'h0E, 8'h0F, 8'hDA, 8'hDB, 8'hDC: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

  function automatic logic is_known(input logic [7:0] code);
    case (code)
      8'h00, 8'h01, 8'h02, 8'h03, 8'h10, 8'h11, 8'h12, 8'h13, 8'h20,
      8'h21, 8'h26, 8'h28, 8'h29, 8'h34, 8'h35, 8'h37, 8'hB0, 8'hB1,
      8'hB4, 8'hC2: return 1'b1;
      default:      return is_read(code);
    endcase
  endfunction

  // index of lowest set bit in a nibble (nibble assumed non-zero)
  function automatic logic [2:0] low_set_index(input logic [3:0] n);
    if (n[0])      return 3'd0;
    else if (n[1]) return 3'd1;
    else if (n[2]) return 3'd2;
    else           return 3'd3;
  endfunction

  // four response bytes, entry 0 in the top byte
  function automatic logic [31:0] read_payload(input logic [7:0] code,
                                               input lcdc_flags_t f,
                                               input logic [23:0] id);
    case (code)
      8'h04: return {id, 8'h00};
      8'h06, 8'h07, 8'h08: return {8'h01, 24'h0};
      8'h09: return {f.booster, 7'b0,
                     4'h5, 1'b0, f.partial, f.sleep, f.normal,
                     f.scroll, 1'b0, f.invert, 2'b0, f.disp_on, f.te, f.gamma[2],
                     f.gamma[1:0], 6'b0};
      8'h0A: return {f.booster, f.sleep, f.partial, f.sleep, f.normal,
                     f.disp_on, 2'b0, 24'h0};
      8'h0C: return {8'h05, 24'h0};
      8'h0D: return {f.scroll, 1'b0, f.invert, 2'b0, f.gamma, 24'h0};
      8'h0E: return {f.te, 7'b0, 24'h0};
      8'h0F: return {f.diag, 24'h0};
      8'hDA: return {id[23:16], 24'h0};
      8'hDB: return {id[15:8], 24'h0};
      8'hDC: return {id[7:0], 24'h0};
      default: return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/lcdc_param_track.sv
module lcdc_param_track #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic [CNT_W-1:0] need_cnt,
  output logic             new_cmd,
  output logic             param_done,
  output logic [7:0]       cur_cmd
);
  logic [CNT_W-1:0] pending;

  assign new_cmd    = rx_valid && (pending == '0);
  assign param_done = rx_valid && (pending == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= '0;
      cur_cmd <= '0;
    end else if (new_cmd) begin
      cur_cmd <= rx_byte;
      pending <= need_cnt;
    end else if (rx_valid) begin
      pending <= pending - CNT_W'(1);
    end
  end

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(pending));
  p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && pending != '0) |=> (pending == $past(pending) - CNT_W'(1)) && $stable(cur_cmd));
endmodule

// File: rtl/lcdc_mode_regs.sv
module lcdc_mode_regs
  import lcdc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_evt,
  input  logic [7:0]  cmd_code,
  input  logic        param_evt,
  input  logic [7:0]  param_cmd,
  input  logic [7:0]  param_byte,
  output lcdc_flags_t flags
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= flags_init();
    end else if (cmd_evt) begin
      case (cmd_code)
        8'h01: flags <= flags_init();
        8'h02: flags.booster <= 1'b0;
        8'h03: flags.booster <= 1'b1;
        8'h10: flags.sleep <= 1'b1;
        8'h11: begin
          flags.sleep   <= 1'b0;
          flags.diag[6] <= ~flags.diag[6];
        end
        8'h12: {flags.partial, flags.normal, flags.scroll} <= 3'b100;
        8'h13: {flags.partial, flags.normal, flags.scroll} <= 3'b010;
        8'h37: {flags.partial, flags.normal, flags.scroll} <= 3'b001;
        8'h20: flags.invert <= 1'b0;
        8'h21: flags.invert <= 1'b1;
        8'h28: flags.disp_on <= 1'b0;
        8'h29: flags.disp_on <= 1'b1;
        8'h34: flags.te <= 1'b0;
        default: ;
      endcase
    end else if (param_evt) begin
      case (param_cmd)
        8'h26: if (param_byte[3:0] != 4'h0) flags.gamma <= low_set_index(param_byte[3:0]);
        8'h35: flags.te <= 1'b1;
        default: ;
      endcase
    end
  end

  p_mode_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({flags.partial, flags.normal, flags.scroll}) == 1);
  p_sleep_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_evt && cmd_code == 8'h11) |=> (!flags.sleep && (flags.diag[6] != $past(flags.diag[6]))));
  p_gamma_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (param_evt && param_cmd == 8'h26 && param_byte[3:0] == 4'h0) |=> $stable(flags.gamma));
endmodule

// File: rtl/lcdc_resp_buf.sv
module lcdc_resp_buf #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             load,
  input  logic [DEPTH*8-1:0] load_vec,
  output logic [7:0]       tx_byte
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]       entry [DEPTH];
  logic [PTR_W-1:0] ptr;
  logic             exhausted;

  assign exhausted = (ptr >= PTR_W'(DEPTH));
  assign tx_byte   = exhausted ? 8'h00 : entry[ptr[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= PTR_W'(DEPTH);
      for (int i = 0; i < DEPTH; i++) entry[i] <= 8'h00;
    end else if (load) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) entry[i] <= load_vec[(DEPTH-1-i)*8 +: 8];
    end else if (advance && !exhausted) begin
      ptr <= ptr + PTR_W'(1);
    end
  end

  p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PTR_W'(DEPTH));
  p_stay_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exhausted && !load) |=> (tx_byte == 8'h00));
endmodule

// File: rtl/lcdc_cmd_interp.sv
module lcdc_cmd_interp
  import lcdc_pkg::*;
#(
  parameter int          RESP_DEPTH = 4,
  parameter int          CNT_W      = 2,
  parameter logic [23:0] PANEL_ID   = 24'h838F03
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic [7:0] tx_byte,
  output logic       cmd_error
);
  localparam int VEC_W = RESP_DEPTH * 8;

  logic             new_cmd, param_done;
  logic [7:0]       cur_cmd;
  logic [CNT_W-1:0] need_cnt;
  logic             rd_load;
  logic [VEC_W-1:0] rd_vec;
  lcdc_flags_t      flags;

  assign need_cnt = CNT_W'(param_need(rx_byte));
  assign rd_load  = new_cmd && is_read(rx_byte);

  always_comb begin
    rd_vec = '0;
    rd_vec[VEC_W-1 -: 32] = read_payload(rx_byte, flags, PANEL_ID);
  end

  lcdc_param_track #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .need_cnt(need_cnt), .new_cmd(new_cmd), .param_done(param_done),
    .cur_cmd(cur_cmd)
  );

  lcdc_mode_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_evt(new_cmd), .cmd_code(rx_byte),
    .param_evt(param_done), .param_cmd(cur_cmd), .param_byte(rx_byte),
    .flags(flags)
  );

  lcdc_resp_buf #(.DEPTH(RESP_DEPTH)) u_resp (
    .clk(clk), .rst_n(rst_n), .advance(rx_valid), .load(rd_load),
    .load_vec(rd_vec), .tx_byte(tx_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_error <= 1'b0;
    else        cmd_error <= new_cmd && !is_known(rx_byte);
  end

  p_err_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_error |-> $past(rx_valid));
  p_err_keeps_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_error |-> $stable(flags));
  p_reset_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (new_cmd && rx_byte == 8'h01) |=> (flags == flags_init()));
endmodule

// File: tb/lcdc_cmd_interp_tb_top.sv
module lcdc_cmd_interp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int ID_VAL     = 'h838F03;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [7:0] tx_byte;
  logic       cmd_error;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcdc_cmd_interp dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_byte(tx_byte), .cmd_error(cmd_error)
  );

  // behavioural reference model
  int resp_q[$];
  int m_sleep, m_boost, m_te, m_part, m_norm, m_scrl, m_inv, m_on, m_gam, m_diag;
  int m_pend = 0;
  int m_cur  = 0;

  task automatic model_flags_init();
    m_sleep = 1; m_boost = 0; m_te = 0; m_part = 0; m_norm = 1;
    m_scrl = 0; m_inv = 0; m_on = 1; m_gam = 0; m_diag = 176;
  endtask

  task automatic reload(input int n, input int b0, input int b1, input int b2, input int b3);
    resp_q.delete();
    if (n > 0) resp_q.push_back(b0);
    if (n > 1) resp_q.push_back(b1);
    if (n > 2) resp_q.push_back(b2);
    if (n > 3) resp_q.push_back(b3);
  endtask

  task automatic model_step(input int b, output int err);
    err = 0;
    if (m_pend == 0) begin
      m_cur = b;
      case (b)
        'h00, 'hB4: ;
        'h01: model_flags_init();
        'h02: m_boost = 0;
        'h03: m_boost = 1;
        'h10: m_sleep = 1;
        'h11: begin m_sleep = 0; m_diag = m_diag ^ 64; end
        'h12: begin m_part = 1; m_norm = 0; m_scrl = 0; end
        'h13: begin m_part = 0; m_norm = 1; m_scrl = 0; end
        'h37: begin m_part = 0; m_norm = 0; m_scrl = 1; end
        'h20: m_inv = 0;
        'h21: m_inv = 1;
        'h28: m_on = 0;
        'h29: m_on = 1;
        'h34: m_te = 0;
        'h26, 'h35: m_pend = 1;
        'hB0, 'hB1, 'hC2: m_pend = 2;
        'h04: reload(3, ID_VAL / 65536, (ID_VAL / 256) % 256, ID_VAL % 256, 0);
        'h06, 'h07, 'h08: reload(1, 1, 0, 0, 0);
        'h09: reload(4, m_boost * 128,
                     80 + m_part * 4 + m_sleep * 2 + m_norm,
                     m_scrl * 128 + m_inv * 32 + m_on * 4 + m_te * 2 + m_gam / 4,
                     (m_gam % 4) * 64);
        'h0A: reload(1, m_boost * 128 + m_sleep * 64 + m_part * 32 + m_sleep * 16
                        + m_norm * 8 + m_on * 4, 0, 0, 0);
        'h0B: reload(1, 0, 0, 0, 0);
        'h0C: reload(1, 5, 0, 0, 0);
        'h0D: reload(1, m_scrl * 128 + m_inv * 32 + m_gam, 0, 0, 0);
        'h0E: reload(1, m_te * 128, 0, 0, 0);
        'h0F: reload(1, m_diag, 0, 0, 0);
        'hDA: reload(1, ID_VAL / 65536, 0, 0, 0);
        'hDB: reload(1, (ID_VAL / 256) % 256, 0, 0, 0);
        'hDC: reload(1, ID_VAL % 256, 0, 0, 0);
        default: err = 1;
      endcase
    end else begin
      m_pend = m_pend - 1;
      if (m_pend == 0) begin
        if (m_cur == 'h26) begin
          for (int k = 3; k >= 0; k--) if (((b >> k) & 1) == 1) m_gam = k;
        end else if (m_cur == 'h35) begin
          m_te = 1;
        end
      end
    end
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  // one transfer; called at a falling edge, returns at the next falling edge
  task automatic send(input int b, input string tag);
    int exp_tx;
    int exp_err;
    rx_valid = 1'b1;
    rx_byte  = 8'(b);
    #1;
    exp_tx = 0;
    if (resp_q.size() > 0) exp_tx = resp_q.pop_front();
    check(tag, "tx_byte", int'(tx_byte), exp_tx);
    model_step(b, exp_err);
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
    check(tag, "cmd_error", int'(cmd_error), exp_err);
  endtask

  task automatic drain(input int n, input string tag);
    for (int i = 0; i < n; i++) send('h00, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, "idle cmd_error", int'(cmd_error), 0);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    model_flags_init();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "reset tx_byte", int'(tx_byte), 0);
    check("R1", "reset cmd_error", int'(cmd_error), 0);
    @(negedge clk);

    // R1 / R4 / R2: reset status, then exhaustion
    send('h09, "R4"); drain(6, "R2");
    send('h0F, "R1"); drain(2, "R1");
    // R3: ID reads
    send('h04, "R3"); drain(5, "R3");
    send('hDA, "R3"); send('hDB, "R3"); send('hDC, "R3"); drain(2, "R3");
    // R2: read issued while an older read is half drained
    send('h09, "R2"); send('h00, "R2"); send('h0C, "R2"); drain(3, "R2");
    // R6: sleep out toggles diag bit 6, sleep in
    send('h11, "R6"); send('h0F, "R6"); send('h0A, "R6"); drain(2, "R6");
    send('h10, "R6"); send('h0A, "R6"); send('h11, "R6"); send('h0F, "R6"); drain(1, "R6");
    send('h11, "R6"); send('h0F, "R6"); drain(1, "R6");
    // R10: simple flags
    send('h03, "R10"); send('h21, "R10"); send('h28, "R10");
    send('h09, "R10"); drain(4, "R10");
    send('h0D, "R10"); send('h0A, "R10"); drain(1, "R10");
    send('h02, "R10"); send('h20, "R10"); send('h29, "R10"); send('h09, "R10"); drain(4, "R10");
    // R7: mode selects
    send('h12, "R7"); send('h09, "R7"); drain(4, "R7");
    send('h37, "R7"); send('h09, "R7"); drain(3, "R7"); send('h0D, "R7"); drain(1, "R7");
    send('h13, "R7"); send('h0A, "R7"); drain(1, "R7");
    // R9 / R8: gamma with parameter byte that looks like a read command
    send('h26, "R8"); send('h04, "R8"); send('h09, "R9"); drain(4, "R9");
    send('h26, "R9"); send('h00, "R9"); send('h0D, "R9"); drain(1, "R9");
    send('h26, "R9"); send('h38, "R9"); send('h09, "R9"); drain(4, "R9");
    send('h26, "R9"); send('hF3, "R9"); send('h0D, "R9"); drain(1, "R9");
    // R8 / R10: tearing effect
    send('h35, "R8"); send('hFF, "R8"); send('h0E, "R8"); drain(1, "R8");
    send('h34, "R10"); send('h0E, "R10"); drain(1, "R10");
    // R8: two discarded parameters that carry command codes
    send('hB0, "R8"); send('h01, "R8"); send('h10, "R8"); send('h0A, "R8"); drain(1, "R8");
    send('hC2, "R8"); send('h28, "R8"); send('h21, "R8"); send('h09, "R8"); drain(4, "R8");
    send('hB1, "R8"); send('h05, "R8"); send('h2C, "R8"); drain(1, "R8");
    // R12: undecoded commands
    send('h2C, "R12"); idle(2, "R12");
    send('h05, "R12"); send('hFF, "R12"); send('hB4, "R12");
    send('h09, "R12"); drain(4, "R12");
    // R5: other single reads
    send('h0C, "R5"); send('h06, "R5"); send('h07, "R5"); send('h08, "R5");
    send('h0B, "R5"); send('h0D, "R5"); drain(1, "R5");
    // R11: software reset with a readback still queued
    send('h03, "R11"); send('h21, "R11"); send('h26, "R11"); send('h08, "R11");
    send('h09, "R11"); send('h01, "R11"); drain(3, "R11");
    send('h09, "R11"); drain(4, "R11"); send('h0F, "R11"); drain(1, "R11");
    idle(3, "R12");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule